// File: doc/BRIEF.md
# Single-Wire Parity Chunk Engine

This block is the bit-level engine for a half-duplex link that shares one wire with a pull-up. It is started through a command handshake. A command selects one of four operations and gives a chunk length and transmit data; the engine runs the operation and pulses `done` when it ends.

On transmit the engine drives a low synchronisation pulse. A short high mark follows, then the data bits, most significant first, and then an even parity bit. After the parity bit it leaves the wire driven low, so that the next synchronisation pulse has an edge. On receive it waits for the rising edge that ends the other side's synchronisation pulse and samples each bit half a bit period after that bit starts. It reports the chunk, a parity error for that chunk, and a parity error flag that is kept across a whole packet.

Two further operations hand ownership of the wire from one side to the other. A higher layer chains the operations into packets and transactions. That layer is outside this block.

Top module: `swire_chunk_engine`

## Requirements
- R1: A command is accepted on a clock edge where `start` is high and `busy` is low. `busy` is high from the next cycle until the operation ends. `done` is then high for exactly one cycle with `busy` low. A `start` seen while `busy` is high has no effect.
- R2: Operations are chosen by `op`: 0 transmit chunk, 1 receive chunk, 2 sender-to-receiver turnaround, 3 receiver-to-sender turnaround. A transmit drives `line_oe` high and `line_out` low for BIT_CYC cycles from the accepting edge, then drives `line_out` high for SYNC_HI cycles.
- R3: The chunk length is `len` for values 1 to 8; 0 and values above 8 mean 8. Transmit sends the low `len` bits of `tx_data`, highest first, each held for BIT_CYC cycles, starting right after the high mark.
- R4: After the data bits a parity bit equal to the XOR of the sent data bits is held for BIT_CYC cycles. At the end of it `line_out` goes low with `line_oe` still high, and `done` pulses.
- R5: Receive waits for the synchronised line to be low and then high. From that rising edge it lets SYNC_HI cycles pass, then samples each data bit and the parity bit floor(BIT_CYC/2) cycles into its period. It then waits the remaining BIT_CYC-floor(BIT_CYC/2) cycles. `rx_data` holds the chunk right-aligned, with the first bit received as its most significant bit.
- R6: If the line is not seen low within 5 bit periods of acceptance, receive treats that moment as the rising edge and goes on sampling.
- R7: At the end of a receive, `rx_perr` is 1 exactly when the sampled parity bit differs from the XOR of the sampled data bits. `pkt_perr` collects these errors and keeps them until a `pkt_clr` pulse clears it.
- R8: Sender-to-receiver turnaround drives the line low for BIT_CYC cycles and then high for floor(BIT_CYC/2) cycles. It then releases the wire (`line_oe` low) for floor(BIT_CYC/2) cycles, after which `done` pulses.
- R9: Receiver-to-sender turnaround waits for the synchronisation edge as in R5 and R6. BIT_CYC cycles after that edge it drives `line_oe` high with `line_out` low, and `done` pulses floor(BIT_CYC/2) cycles later.
- R10: A receive leaves `line_oe` and `line_out` unchanged.
- R11: After reset `busy`, `done`, `rx_data`, `rx_perr`, `pkt_perr` and `line_oe` are 0 and `line_out` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Command strobe |
| op | input | 2 | Operation select (R2) |
| len | input | 4 | Chunk length in bits |
| tx_data | input | 8 | Data to transmit, right-aligned |
| pkt_clr | input | 1 | Clears the packet parity error flag |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| rx_data | output | 8 | Last received chunk, right-aligned |
| rx_perr | output | 1 | Parity error of the last received chunk |
| pkt_perr | output | 1 | Sticky parity error since the last clear |
| line_oe | output | 1 | Drive enable for the wire |
| line_out | output | 1 | Value driven on the wire |
| line_in | input | 1 | Sampled wire level |

## Verification
On transmit, every line level is due at a cycle count from the accepting edge that can be worked out in advance. The sync low comes first, then the high mark after BIT_CYC cycles, then bit k after BIT_CYC+SYNC_HI+k·BIT_CYC cycles. `done` is due after BIT_CYC+SYNC_HI+(len+1)·BIT_CYC cycles. The bench samples each level at the middle of its window on falling edges, and checks `done` on the exact cycle it is due. On receive, the two synchroniser flops and the edge detection add a few cycles between the bench's rising edge and the result. So the bench drives a full frame and then polls for `done` in a short bounded window, and it checks the turnaround steps a quarter period inside each phase.

// File: rtl/swire_chunk_engine.sv
module swire_chunk_engine #(
  parameter int CLK_MHZ     = 16,
  parameter int BIT_US      = 6,
  parameter int BIT_CYC     = CLK_MHZ * BIT_US,
  parameter int SYNC_HI     = 4,
  parameter int WAIT_PERIODS = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [1:0] op,
  input  logic [3:0] len,
  input  logic [7:0] tx_data,
  input  logic       pkt_clr,
  output logic       busy,
  output logic       done,
  output logic [7:0] rx_data,
  output logic       rx_perr,
  output logic       pkt_perr,
  output logic       line_oe,
  output logic       line_out,
  input  logic       line_in
);

  localparam int HALF1 = BIT_CYC / 2;
  localparam int HALF2 = BIT_CYC - HALF1;
  localparam int TMO   = WAIT_PERIODS * BIT_CYC;
  localparam int CW    = $clog2(TMO + 1);
  localparam logic [CW-1:0] LD_BIT = CW'(BIT_CYC - 1);
  localparam logic [CW-1:0] LD_H1  = CW'(HALF1 - 1);
  localparam logic [CW-1:0] LD_H2  = CW'(HALF2 - 1);
  localparam logic [CW-1:0] LD_HI  = CW'(SYNC_HI - 1);
  localparam logic [CW-1:0] TMO_END = CW'(TMO - 1);

  localparam logic [1:0] OP_TX = 2'd0, OP_RX = 2'd1, OP_S2R = 2'd2, OP_R2S = 2'd3;

  typedef enum logic [3:0] {
    S_IDLE, S_SYNC_LO, S_SYNC_HI, S_TX_BIT, S_WAIT_LO, S_WAIT_HI,
    S_ALIGN, S_RX_H1, S_RX_H2, S_TA_REL, S_R2S_WAIT, S_R2S_HALF
  } state_t;

  state_t        state;
  logic [1:0]    op_q;
  logic [3:0]    left;
  logic [8:0]    frame;
  logic [CW-1:0] cnt;
  logic          sy1, sy2;
  logic [7:0]    rx_sh;
  logic          par_acc, perr_tmp;
  logic          oe_q, out_q, done_q, rx_perr_q, pkt_perr_q;
  logic [7:0]    rx_data_q;

  wire [3:0] len_eff  = (len == 4'd0 || len > 4'd8) ? 4'd8 : len;
  wire [8:0] mask9    = (9'd1 << len_eff) - 9'd1;
  wire [7:0] tx_mask  = tx_data & mask9[7:0];
  wire       tx_par   = ^tx_mask;
  wire [8:0] frame_init = {tx_mask, tx_par} << (4'd8 - len_eff);
  wire       tick     = (cnt == '0);
  wire       pkt_base = pkt_clr ? 1'b0 : pkt_perr_q;

  assign busy     = (state != S_IDLE);
  assign done     = done_q;
  assign rx_data  = rx_data_q;
  assign rx_perr  = rx_perr_q;
  assign pkt_perr = pkt_perr_q;
  assign line_oe  = oe_q;
  assign line_out = out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sy1 <= 1'b1;
      sy2 <= 1'b1;
    end else begin
      sy1 <= line_in;
      sy2 <= sy1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      op_q       <= OP_TX;
      left       <= '0;
      frame      <= '0;
      cnt        <= '0;
      rx_sh      <= '0;
      par_acc    <= 1'b0;
      perr_tmp   <= 1'b0;
      oe_q       <= 1'b0;
      out_q      <= 1'b1;
      done_q     <= 1'b0;
      rx_data_q  <= '0;
      rx_perr_q  <= 1'b0;
      pkt_perr_q <= 1'b0;
    end else begin
      done_q     <= 1'b0;
      pkt_perr_q <= pkt_base;
      cnt        <= cnt - 1'b1;
      case (state)
        S_IDLE: begin
          if (start) begin
            op_q    <= op;
            left    <= len_eff + 4'd1;
            frame   <= frame_init;
            rx_sh   <= '0;
            par_acc <= 1'b0;
            if (op == OP_TX || op == OP_S2R) begin
              oe_q  <= 1'b1;
              out_q <= 1'b0;
              cnt   <= LD_BIT;
              state <= S_SYNC_LO;
            end else begin
              cnt   <= '0;
              state <= S_WAIT_LO;
            end
          end
        end
        S_SYNC_LO: if (tick) begin
          out_q <= 1'b1;
          cnt   <= (op_q == OP_TX) ? LD_HI : LD_H1;
          state <= S_SYNC_HI;
        end
        S_SYNC_HI: if (tick) begin
          if (op_q == OP_TX) begin
            out_q <= frame[8];
            frame <= frame << 1;
            cnt   <= LD_BIT;
            state <= S_TX_BIT;
          end else begin
            out_q <= 1'b0;
            oe_q  <= 1'b0;
            cnt   <= LD_H1;
            state <= S_TA_REL;
          end
        end
        S_TX_BIT: if (tick) begin
          if (left == 4'd1) begin
            out_q  <= 1'b0;
            done_q <= 1'b1;
            state  <= S_IDLE;
          end else begin
            left  <= left - 4'd1;
            out_q <= frame[8];
            frame <= frame << 1;
            cnt   <= LD_BIT;
          end
        end
        S_WAIT_LO: begin
          if (!sy2) begin
            state <= S_WAIT_HI;
          end else if (cnt == TMO_END) begin
            cnt   <= (op_q == OP_RX) ? LD_HI : LD_BIT;
            state <= (op_q == OP_RX) ? S_ALIGN : S_R2S_WAIT;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_WAIT_HI: begin
          if (sy2) begin
            cnt   <= (op_q == OP_RX) ? LD_HI : LD_BIT;
            state <= (op_q == OP_RX) ? S_ALIGN : S_R2S_WAIT;
          end
        end
        S_ALIGN: if (tick) begin
          cnt   <= LD_H1;
          state <= S_RX_H1;
        end
        S_RX_H1: if (tick) begin
          if (left == 4'd1) begin
            perr_tmp <= sy2 ^ par_acc;
          end else begin
            rx_sh   <= {rx_sh[6:0], sy2};
            par_acc <= par_acc ^ sy2;
          end
          cnt   <= LD_H2;
          state <= S_RX_H2;
        end
        S_RX_H2: if (tick) begin
          if (left == 4'd1) begin
            rx_data_q  <= rx_sh;
            rx_perr_q  <= perr_tmp;
            pkt_perr_q <= pkt_base | perr_tmp;
            done_q     <= 1'b1;
            state      <= S_IDLE;
          end else begin
            left  <= left - 4'd1;
            cnt   <= LD_H1;
            state <= S_RX_H1;
          end
        end
        S_TA_REL: if (tick) begin
          done_q <= 1'b1;
          state  <= S_IDLE;
        end
        S_R2S_WAIT: if (tick) begin
          oe_q  <= 1'b1;
          out_q <= 1'b0;
          cnt   <= LD_H1;
          state <= S_R2S_HALF;
        end
        S_R2S_HALF: if (tick) begin
          done_q <= 1'b1;
          state  <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_START_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start)); // R1
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R1
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R1
  AST_SYNC_DRIVEN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_SYNC_LO) |-> (line_oe && !line_out)); // R2
  AST_TX_LEAVES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op_q == OP_TX) |-> (line_oe && !line_out)); // R4
  AST_PKT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_perr && !pkt_clr) |=> pkt_perr); // R7
  AST_S2R_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op_q == OP_S2R) |-> !line_oe); // R8
  AST_R2S_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op_q == OP_R2S) |-> (line_oe && !line_out)); // R9
  AST_RX_HANDS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && op_q == OP_RX) |=> ($stable(line_oe) && $stable(line_out))); // R10

endmodule

// File: tb/swire_chunk_engine_tb.sv
module swire_chunk_engine_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int P = 96;
  localparam int H = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, pkt_clr = 1'b0, line_in = 1'b1;
  logic [1:0] op = 2'd0;
  logic [3:0] len = 4'd8;
  logic [7:0] tx_data = 8'd0;
  logic busy, done, rx_perr, pkt_perr, line_oe, line_out;
  logic [7:0] rx_data;
  int n_chk = 0, n_bad = 0;
  bit wd_hit = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  swire_chunk_engine #(.CLK_MHZ(16), .BIT_US(6), .BIT_CYC(P), .SYNC_HI(H), .WAIT_PERIODS(5)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .len(len), .tx_data(tx_data),
    .pkt_clr(pkt_clr), .busy(busy), .done(done), .rx_data(rx_data), .rx_perr(rx_perr),
    .pkt_perr(pkt_perr), .line_oe(line_oe), .line_out(line_out), .line_in(line_in));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic go(input logic [1:0] o, input logic [3:0] l, input logic [7:0] d);
    @(negedge clk);
    op = o; len = l; tx_data = d; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(input int limit, input string req);
    bit seen = 1'b0;
    for (int i = 0; i < limit && !seen; i++) begin
      @(negedge clk);
      if (done) seen = 1'b1;
    end
    chk(req, seen, 1'b1);
  endtask

  task automatic t_reset;
    chk("R11 busy", busy, 0);
    chk("R11 done", done, 0);
    chk("R11 rx_data", rx_data, 0);
    chk("R11 perr", {rx_perr, pkt_perr}, 0);
    chk("R11 line", {line_oe, line_out}, 2'b01);
  endtask

  task automatic t_tx(input logic [7:0] d, input logic [3:0] l);
    int n = (l == 0 || l > 8) ? 8 : int'(l);
    logic [7:0] m = 8'((16'd1 << n) - 1);
    logic par = ^(d & m);
    go(2'd0, l, d);
    chk("R1 busy after accept", busy, 1);
    repeat (P/2) @(negedge clk);
    chk("R2 sync low", {line_oe, line_out}, 2'b10);
    repeat (P/2 + 1) @(negedge clk);
    chk("R2 sync high mark", {line_oe, line_out}, 2'b11);
    repeat (H - 1 + P/2) @(negedge clk);
    for (int k = 0; k <= n; k++) begin
      if (k < n) chk("R3 data bit", line_out, d[n-1-k]);
      else       chk("R4 parity bit", line_out, par);
      if (k < n) repeat (P) @(negedge clk);
    end
    repeat (P/2) @(negedge clk);
    chk("R4 done on time", done, 1);
    chk("R4 line low after parity", {line_oe, line_out}, 2'b10);
  endtask

  task automatic t_busy_ignore;
    go(2'd0, 4'd1, 8'h01);
    repeat (P) @(negedge clk);
    op = 2'd2; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done(4*P, "R1 first op completes");
    repeat (3) @(negedge clk);
    chk("R1 start while busy ignored", busy, 0);
    chk("R1 line untouched after ignored start", {line_oe, line_out}, 2'b10);
  endtask

  task automatic t_rx(input logic [7:0] d, input logic [3:0] l, input bit bad, input int lead);
    int n = (l == 0 || l > 8) ? 8 : int'(l);
    logic [7:0] m = 8'((16'd1 << n) - 1);
    logic par = (^(d & m)) ^ bad;
    logic [1:0] line_before = {line_oe, line_out};
    go(2'd1, l, 8'h00);
    repeat (lead) @(negedge clk);
    line_in = 1'b0;
    repeat (P) @(negedge clk);
    line_in = 1'b1;
    repeat (H) @(negedge clk);
    for (int k = 0; k <= n; k++) begin
      line_in = (k < n) ? d[n-1-k] : par;
      repeat (P) @(negedge clk);
    end
    line_in = 1'b0;
    wait_done(40, "R5 receive completes");
    chk("R5 rx_data", rx_data, d & m);
    chk("R7 rx_perr", rx_perr, bad);
    chk("R10 line unchanged by receive", {line_oe, line_out}, line_before);
    line_in = 1'b1;
  endtask

  task automatic t_pkt_flag;
    t_rx(8'h3C, 4'd8, 1'b1, 10);
    chk("R7 pkt_perr set", pkt_perr, 1);
    t_rx(8'h66, 4'd8, 1'b0, 10);
    chk("R7 pkt_perr sticky", pkt_perr, 1);
    @(negedge clk); pkt_clr = 1'b1;
    @(negedge clk); pkt_clr = 1'b0;
    chk("R7 pkt_perr cleared", pkt_perr, 0);
  endtask

  task automatic t_timeout;
    line_in = 1'b1;
    go(2'd1, 4'd8, 8'h00);
    wait_done(16*P, "R6 timeout receive completes");
    chk("R6 rx_data all ones", rx_data, 8'hFF);
    chk("R6 parity mismatch", rx_perr, 1);
  endtask

  task automatic t_s2r;
    go(2'd2, 4'd8, 8'h00);
    repeat (P/2) @(negedge clk);
    chk("R8 sync low", {line_oe, line_out}, 2'b10);
    repeat (P/2 + P/4) @(negedge clk);
    chk("R8 high half", {line_oe, line_out}, 2'b11);
    repeat (P/2) @(negedge clk);
    chk("R8 released", line_oe, 0);
    chk("R8 not yet done", done, 0);
    repeat (P/4) @(negedge clk);
    chk("R8 done on time", done, 1);
  endtask

  task automatic t_r2s;
    go(2'd3, 4'd8, 8'h00);
    repeat (20) @(negedge clk);
    line_in = 1'b0;
    repeat (P) @(negedge clk);
    line_in = 1'b1;
    repeat (P/2) @(negedge clk);
    chk("R9 still released", line_oe, 0);
    repeat (P/2 + P/4) @(negedge clk);
    chk("R9 drives low", {line_oe, line_out}, 2'b10);
    chk("R9 busy during half", busy, 1);
    wait_done(P/2, "R9 done");
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_tx(8'hA5, 4'd8);
        t_tx(8'h35, 4'd7);
        t_tx(8'h01, 4'd1);
        t_tx(8'h81, 4'd0);
        t_tx(8'h0F, 4'd12);
        t_busy_ignore();
        t_rx(8'hC3, 4'd8, 1'b0, 30);
        t_rx(8'h5A, 4'd7, 1'b0, 200);
        t_rx(8'h01, 4'd1, 1'b0, 5);
        t_pkt_flag();
        t_timeout();
        t_s2r();
        t_r2s();
        t_tx(8'h96, 4'd8);
      end
      begin
        repeat (150000) @(posedge clk);
        wd_hit = 1'b1;
      end
    join_any
    if (wd_hit) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=expired expected=finished");
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule